// File: doc/BRIEF.md
# Serial Command Front End for a Dual Power Switch

This block sits between a host processor and a two-channel power switch controller. The host talks to it through a 16-bit SPI slave port. Each frame the host sends carries three things: a register address, nine bits of data, and one bit that keeps a watchdog alive. While that frame is being clocked in, the block shifts a status word out at the same time. That status word was captured when chip select fell. Two per-channel control registers and one global register are held on chip. The lowest bit of each channel register commands that channel's output. A status-select register chooses which content the next frame returns.

Watchdog servicing works only by change. A valid frame whose top bit differs from the top bit of the previous valid frame restarts the timer. A frame that repeats the previous value leaves the timer running. If the timer expires while the watchdog enable input is high, the block enters fail-safe mode:
- every register except the power-on flag returns to its reset value;
- the channel outputs follow the direct input pins;
- the normal-mode flag in the status word reads 0.

The next valid frame that toggles the watchdog bit returns the block to normal mode.

Top module: `sw_spi_regif`

## Requirements
- R1: A frame is 16 bits, MSB first on both data lines, sampled on SCLK rising edges and changed on falling edges while chip select is low. A write takes effect after chip select rises, and a later frame can read the written value back.
- R2: A frame that saw any number of SCLK rising edges other than 16 writes no register and does not service the watchdog.
- R3: Bits 12:10 hold the address and bits 8:0 the data; bits 14 and 9 are ignored. Address 1 writes a channel register, with bit 13 choosing the channel (0 selects channel 0, 1 selects channel 1). Address 2 writes the global register. Addresses 3 to 7 write nothing.
- R4: Address 0 stores bits 4:0 as the readback select. The next frame then returns one payload: value 0 gives the output state, 1 gives channel 0's register, 2 gives channel 1's register, 3 gives the global register, and any other value gives zero.
- R5: The returned word has bit 15 = 0, bit 14 = normal-mode flag, bit 13 = power-on flag, bits 12:9 = 0 and bits 8:0 = payload. The output-state payload puts channel 1 in bit 1 and channel 0 in bit 0. The word is captured when chip select falls.
- R6: After reset all registers and the select are zero, the power-on flag is 1, the outputs are off and the normal-mode output is 1.
- R7: In normal mode each channel output equals bit 0 of its channel register.
- R8: With the watchdog enabled, fail-safe is entered WD_LIMIT cycles after the last valid frame whose bit 15 differed from the previous valid frame's bit 15. After reset that previous value counts as 0. A frame that repeats bit 15 does not restart the count.
- R9: With the watchdog enable input low, fail-safe is never entered.
- R10: On entering fail-safe, the channel, global and select registers return to zero. The outputs then follow the direct input pins, and the normal-mode flag (port and status bit 14) reads 0.
- R11: A valid frame that toggles bit 15 leaves fail-safe. Its write is applied.
- R12: The power-on flag is cleared only by a valid frame to address 0. Entering fail-safe leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial status data to host |
| wd_enable | input | 1 | High enables the watchdog |
| dir_in | input | 2 | Direct output commands used in fail-safe |
| out_on | output | 2 | Registered channel output commands |
| normal_mode | output | 1 | High outside fail-safe |

## Verification
The bench builds the block with WD_LIMIT set to 400 and two synchronizer stages. With those values, a single toggling frame followed by two repeating frames and a short idle gap is enough to trip the watchdog. The same values let fail-safe entry, recovery and the power-on flag's survival all be exercised within a few thousand cycles. With the SCLK half period at four system clocks, every SCLK edge clears the synchronizers before the next edge arrives. The same margin lets frames of 15 and 17 edges be tested for rejection.

// File: rtl/sw_spi_pkg.sv
package sw_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 9;
  localparam int SEL_W   = 5;
  localparam int N_CH    = 2;
  localparam int WD_BIT  = 15;
  localparam int CH_BIT  = 13;
  localparam int ADDR_LO = 10;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT = 3'd0,
    RA_CHAN = 3'd1,
    RA_GLOB = 3'd2
  } reg_addr_e;
endpackage

// File: rtl/sw_spi_shifter.sv
module sw_spi_shifter #(
  parameter int FW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [FW-1:0] tx_word,
  output logic          miso,
  output logic          frame_ok,
  output logic [FW-1:0] rx_word
);
  localparam int CW = $clog2(FW + 1) + 1;
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] CFULL = CW'(FW);

  logic [SYNC:0]   sck_p;
  logic [SYNC:0]   cs_p;
  logic [SYNC-1:0] si_p;
  logic [CW-1:0]   cnt;
  logic [FW-1:0]   tx_q;
  logic            sck_rise, sck_fall, cs_fall, cs_rise, active, si_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= (SYNC+1)'({sck_p, sclk});
      cs_p  <= (SYNC+1)'({cs_p, cs_n});
      si_p  <= SYNC'({si_p, mosi});
    end
  end

  assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  assign sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  assign cs_fall  = ~cs_p[SYNC-1] & cs_p[SYNC];
  assign cs_rise  = cs_p[SYNC-1] & ~cs_p[SYNC];
  assign active   = ~cs_p[SYNC-1];
  assign si_s     = si_p[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word  <= '0;
      tx_q     <= '0;
      cnt      <= '0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= 1'b0;
      if (cs_fall) begin
        tx_q <= tx_word;
        cnt  <= '0;
      end else if (active) begin
        if (sck_rise) begin
          rx_word <= {rx_word[FW-2:0], si_s};
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end
        if (sck_fall) tx_q <= {tx_q[FW-2:0], 1'b0};
      end
      if (cs_rise) frame_ok <= (cnt == CFULL);
    end
  end

  assign miso = tx_q[FW-1];
endmodule

// File: rtl/sw_wdog.sv
module sw_wdog #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic frame_ok,
  input  logic wd_bit,
  output logic fail_safe,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TLAST = TW'(LIMIT - 1);

  logic [TW-1:0] tmr;
  logic          last_bit;
  logic          kick;

  assign kick   = frame_ok && (wd_bit != last_bit);
  assign expire = enable && !fail_safe && !kick && (tmr == TLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr       <= '0;
      fail_safe <= 1'b0;
      last_bit  <= 1'b0;
    end else begin
      if (frame_ok) last_bit <= wd_bit;
      if (kick) begin
        tmr       <= '0;
        fail_safe <= 1'b0;
      end else if (expire) begin
        tmr       <= '0;
        fail_safe <= 1'b1;
      end else if (!enable || fail_safe) begin
        tmr <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sw_regbank.sv
module sw_regbank
  import sw_spi_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W,
  parameter int NC = N_CH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_ok,
  input  logic [FW-1:0]          rx_word,
  input  logic                   clear,
  output logic [NC-1:0][DW-1:0]  ch_cfg,
  output logic [DW-1:0]          glob_cfg,
  output logic [SW-1:0]          sel,
  output logic                   por,
  output logic [NC+1:0]          wr_stb
);
  reg_addr_e     addr;
  logic [DW-1:0] wdata;

  assign addr  = reg_addr_e'(rx_word[ADDR_LO +: ADDR_W]);
  assign wdata = rx_word[DW-1:0];

  always_comb begin
    wr_stb = '0;
    if (frame_ok) begin
      case (addr)
        RA_STAT: wr_stb[0] = 1'b1;
        RA_GLOB: wr_stb[1] = 1'b1;
        RA_CHAN: begin
          if (rx_word[CH_BIT]) wr_stb[3] = 1'b1;
          else                 wr_stb[2] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || clear)       q <= '0;
      else if (wr_stb[2 + c]) q <= wdata;
    end
    assign ch_cfg[c] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_cfg <= '0;
      sel      <= '0;
      por      <= 1'b1;
    end else if (clear) begin
      glob_cfg <= '0;
      sel      <= '0;
    end else begin
      if (wr_stb[1]) glob_cfg <= wdata;
      if (wr_stb[0]) begin
        sel <= wdata[SW-1:0];
        por <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sw_readback.sv
module sw_readback #(
  parameter int FW = 16,
  parameter int DW = 9,
  parameter int SW = 5,
  parameter int NC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NC-1:0][DW-1:0] ch_cfg,
  input  logic [DW-1:0]         glob_cfg,
  input  logic [SW-1:0]         sel,
  input  logic                  por,
  input  logic                  fail_safe,
  input  logic [NC-1:0]         dir_in,
  output logic [NC-1:0]         out_on,
  output logic [FW-1:0]         tx_word,
  output logic                  normal_mode
);
  localparam int PADW = FW - 3 - DW;

  logic [DW-1:0] payload;

  always_comb begin
    payload = '0;
    if (sel == '0) begin
      payload = DW'(out_on);
    end else if (int'(sel) == NC + 1) begin
      payload = glob_cfg;
    end else begin
      for (int c = 0; c < NC; c++)
        if (int'(sel) == c + 1) payload = ch_cfg[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_on      <= '0;
      tx_word     <= '0;
      normal_mode <= 1'b1;
    end else begin
      for (int c = 0; c < NC; c++)
        out_on[c] <= fail_safe ? dir_in[c] : ch_cfg[c][0];
      tx_word     <= {1'b0, ~fail_safe, por, {PADW{1'b0}}, payload};
      normal_mode <= ~fail_safe;
    end
  end
endmodule

// File: rtl/sw_spi_regif.sv
module sw_spi_regif
  import sw_spi_pkg::*;
#(
  parameter int WD_LIMIT    = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             wd_enable,
  input  logic [N_CH-1:0]  dir_in,
  output logic [N_CH-1:0]  out_on,
  output logic             normal_mode
);
  logic                      frame_ok;
  logic [FRAME_W-1:0]        rx_word;
  logic [FRAME_W-1:0]        tx_word;
  logic                      fail_safe;
  logic                      fs_enter;
  logic [N_CH-1:0][DATA_W-1:0] ch_cfg;
  logic [DATA_W-1:0]         glob_cfg;
  logic [SEL_W-1:0]          sel;
  logic                      por;
  logic [N_CH+1:0]           wr_stb;
  logic                      unused_bits;

  assign unused_bits = ^{rx_word[14], rx_word[9]};

  sw_spi_shifter #(.FW(FRAME_W), .SYNC(SYNC_STAGES)) i_shift (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .miso(spi_miso), .frame_ok(frame_ok), .rx_word(rx_word)
  );

  sw_wdog #(.LIMIT(WD_LIMIT)) i_wdog (
    .clk(clk), .rst(rst), .enable(wd_enable), .frame_ok(frame_ok),
    .wd_bit(rx_word[WD_BIT]), .fail_safe(fail_safe), .expire(fs_enter)
  );

  sw_regbank #(.FW(FRAME_W), .DW(DATA_W), .SW(SEL_W), .NC(N_CH)) i_bank (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .rx_word(rx_word),
    .clear(fs_enter), .ch_cfg(ch_cfg), .glob_cfg(glob_cfg), .sel(sel),
    .por(por), .wr_stb(wr_stb)
  );

  sw_readback #(.FW(FRAME_W), .DW(DATA_W), .SW(SEL_W), .NC(N_CH)) i_rdbk (
    .clk(clk), .rst(rst), .ch_cfg(ch_cfg), .glob_cfg(glob_cfg), .sel(sel),
    .por(por), .fail_safe(fail_safe), .dir_in(dir_in), .out_on(out_on),
    .tx_word(tx_word), .normal_mode(normal_mode)
  );
endmodule

// File: rtl/sw_spi_regif_chk.sv
module sw_spi_regif_chk #(
  parameter int NC = 2,
  parameter int DW = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fail_safe,
  input logic                  wd_enable,
  input logic [NC-1:0]         dir_in,
  input logic [NC-1:0]         out_on,
  input logic                  normal_mode,
  input logic [NC-1:0][DW-1:0] ch_cfg,
  input logic [DW-1:0]         glob_cfg,
  input logic [NC+1:0]         wr_stb
);
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb)); // R3

  AST_TIMEOUT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_safe) |-> $past(wd_enable)); // R9

  AST_FS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_safe) |-> (ch_cfg == '0 && glob_cfg == '0)); // R10

  AST_FS_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (rst)
    fail_safe |=> out_on == $past(dir_in)); // R10

  AST_NORMAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    normal_mode == !$past(fail_safe)); // R10
endmodule

bind sw_spi_regif sw_spi_regif_chk #(.NC(sw_spi_pkg::N_CH), .DW(sw_spi_pkg::DATA_W)) i_chk (
  .clk(clk), .rst(rst), .fail_safe(fail_safe), .wd_enable(wd_enable),
  .dir_in(dir_in), .out_on(out_on), .normal_mode(normal_mode),
  .ch_cfg(ch_cfg), .glob_cfg(glob_cfg), .wr_stb(wr_stb)
);

// File: tb/test_sw_spi_regif.sv
module test_sw_spi_regif;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;
  localparam int WDL = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wd_enable = 1'b0;
  logic [1:0] dir_in = 2'b00;
  logic miso, normal_mode;
  logic [1:0] out_on;

  int total = 0, bad = 0;
  bit done = 0;

  logic [8:0] m_ch [2];
  logic [8:0] m_glob;
  logic [4:0] m_sel;
  logic m_por, m_fs, m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_spi_regif #(.WD_LIMIT(WDL), .SYNC_STAGES(2)) i_sw_spi_regif (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wd_enable(wd_enable), .dir_in(dir_in),
    .out_on(out_on), .normal_mode(normal_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic mreset();
    m_ch[0] = '0; m_ch[1] = '0; m_glob = '0; m_sel = '0;
    m_por = 1'b1; m_fs = 1'b0; m_last = 1'b0;
  endtask

  task automatic mclear();
    m_ch[0] = '0; m_ch[1] = '0; m_glob = '0; m_sel = '0; m_fs = 1'b1;
  endtask

  function automatic logic [1:0] m_out();
    return m_fs ? dir_in : {m_ch[1][0], m_ch[0][0]};
  endfunction

  function automatic logic [15:0] mk_tx();
    logic [8:0] p;
    case (m_sel)
      5'd0: p = {7'b0, m_out()};
      5'd1: p = m_ch[0];
      5'd2: p = m_ch[1];
      5'd3: p = m_glob;
      default: p = '0;
    endcase
    return {1'b0, ~m_fs, m_por, 4'b0000, p};
  endfunction

  function automatic logic [14:0] mkw(input logic ch, input logic [2:0] a, input logic [8:0] d);
    return {1'b0, ch, a, 1'b0, d};
  endfunction

  task automatic commit(input logic [15:0] w);
    case (w[12:10])
      3'd0: begin m_sel = w[4:0]; m_por = 1'b0; end
      3'd1: m_ch[w[13]] = w[8:0];
      3'd2: m_glob = w[8:0];
      default: ;
    endcase
    if (w[15] != m_last) m_fs = 1'b0;
    m_last = w[15];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    mreset();
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n, input string req);
    logic [15:0] exp, r;
    exp = mk_tx();
    r = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HB) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      sclk = 1'b1;
      repeat (HB) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HB) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HB) @(negedge clk);
    if (n >= 16) check({req, " rx"}, 32'(r), 32'(exp));
    if (n == 16) commit(w);
    check({req, " out_on"}, 32'(out_on), 32'(m_out()));
    check({req, " normal"}, 32'(normal_mode), 32'(!m_fs));
  endtask

  task automatic send_t(input logic [14:0] body, input bit tog, input int n, input string req);
    logic d15;
    d15 = tog ? ~m_last : m_last;
    send({d15, body}, n, req);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    mreset();
    do_reset();
    check("R6 normal", 32'(normal_mode), 32'd1);
    check("R6 out_on", 32'(out_on), 32'd0);
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R6");
    send_t(mkw(0, 3'd1, 9'h1A5), 1, 16, "R1");
    check("R7", 32'(out_on), 32'd1);
    send_t(mkw(1, 3'd1, 9'h0F2), 1, 16, "R3");
    send_t(mkw(0, 3'd2, 9'h155), 1, 16, "R3");
    send_t(mkw(0, 3'd0, 9'd1), 1, 16, "R12");
    send_t(mkw(0, 3'd0, 9'd2), 1, 16, "R4");
    send_t(mkw(0, 3'd0, 9'd3), 1, 16, "R4");
    send_t(mkw(0, 3'd0, 9'h015), 1, 16, "R4");
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R4");
    send_t(mkw(0, 3'd3, 9'h1FF), 1, 16, "R5");
    send_t(mkw(0, 3'd0, 9'd1), 1, 16, "R3");
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R3");
    send_t(mkw(0, 3'd1, 9'd0), 1, 15, "R2");
    send_t(mkw(0, 3'd1, 9'd0), 1, 17, "R2");
    send_t(mkw(1, 3'd1, 9'h0F3) | 15'h4000, 1, 16, "R3");
    check("R7", 32'(out_on), 32'd3);

    wd_enable = 1'b1;
    dir_in = 2'b10;
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R8");
    send_t(mkw(0, 3'd0, 9'd0), 0, 16, "R8");
    send_t(mkw(0, 3'd0, 9'd0), 0, 16, "R8");
    check("R8 still normal", 32'(normal_mode), 32'd1);
    repeat (200) @(negedge clk);
    mclear();
    check("R8 timeout", 32'(normal_mode), 32'd0);
    check("R10 pins", 32'(out_on), 32'(2'b10));
    send_t(mkw(0, 3'd0, 9'd1), 1, 16, "R11");
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R10");

    wd_enable = 1'b0;
    repeat (1000) @(negedge clk);
    check("R9", 32'(normal_mode), 32'd1);

    do_reset();
    wd_enable = 1'b1;
    repeat (WDL + 50) @(negedge clk);
    mclear();
    check("R12 fs", 32'(normal_mode), 32'd0);
    send_t(mkw(0, 3'd0, 9'd0), 1, 16, "R12");
    wd_enable = 1'b0;

    done = 1;
    finish_run();
  end
endmodule